// File: doc/BRIEF.md
# Multiplexed LCD display RAM writer

This block is the display memory of a segment LCD driver: 40 columns by 4 rows of single-bit cells. Column n feeds segment output n and row r belongs to backplane r. A stored 1 turns the matching LCD element on and a 0 turns it off. The scan logic picks a backplane row with `row_sel` and reads that row's 40 segment bits at once, so row k is shown while backplane k is active.

Incoming data arrives one whole byte at a time and is stored in the cycle it is accepted. How the byte is unpacked depends on the multiplex mode. In static mode it fills one row. In 1:2, 1:3 and 1:4 modes it fills 2, 3 or 4 rows per column across successive columns. An internal column pointer advances past the columns just written. The pointer can be loaded from `addr_in` with `addr_load`.

The byte input is a valid/ready stream. `wr_ready` is high whenever reset is low, so the block never applies back-pressure. A byte is taken on every rising edge where `wr_valid` and `wr_ready` are both high. The mode and address pins are plain control inputs and are sampled on the same edge.

Top module: `lcd_frame_store`

## Requirements
- R1: `row_data` combinationally returns the 40 cells of row `row_sel`, with bit c of `row_data` being the cell in column c. A 1 means the element is on.
- R2: On an edge with `wr_valid` low, no cell changes.
- R3: With mode 0 (static), byte bits 7 down to 0 go to row 0 of columns p, p+1, …, p+7, where p is the pointer.
- R4: With mode 1 (1:2), byte bits are taken in pairs, most significant first, into rows 0 and 1 of columns p..p+3. The first bit of each pair goes to row 0.
- R5: With mode 2 (1:3), byte bits are taken in triples into rows 0–2 of columns p..p+2. The last column gets only rows 0–1 (bits 1 and 0), and its row 2 keeps its previous value.
- R6: With mode 3 (1:4), byte bits 7..4 go to rows 0..3 of column p and bits 3..0 go to rows 0..3 of column p+1.
- R7: After each accepted byte the pointer advances by 8, 4, 3 or 2 for modes 0..3. Both the pointer and the written columns wrap modulo 40, so column 39 is followed by column 0.
- R8: While `rst` is high on a rising edge, all cells are cleared to 0 and the pointer is set to 0.
- R9: Rows that the current mode does not use (rows 1–3 in static, rows 2–3 in 1:2, row 3 in 1:3) are never changed by a write.
- R10: `addr_load` sets the pointer to `addr_in`, or to 0 if `addr_in` is 40 or more. If a byte is accepted on the same edge, that byte is written starting at the loaded column.
- R11: `wr_ready` is high whenever `rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Byte offered |
| wr_ready | output | 1 | Byte accepted when high with wr_valid |
| wr_byte | input | 8 | Display data byte |
| mode | input | 2 | Multiplex mode: 0 static, 1 1:2, 2 1:3, 3 1:4 |
| addr_load | input | 1 | Load column pointer strobe |
| addr_in | input | 6 | Column to load |
| row_sel | input | 2 | Backplane row to read |
| row_data | output | 40 | Segment bits of the selected row |

## Verification
The assertions check on every cycle that the pointer stays below 40 and steps by the mode's stride with wrap. They also check that idle edges leave the memory untouched and that rows unused by static and 1:2 modes hold their value. Only the bench's scenarios can show the exact bit placement per mode, including the preserved ninth slot in 1:3 mode. The same holds for column wrap within one byte, address loads that collide with a write, out-of-range load values, and the cleared state after reset. The bench compares all four rows against a reference model after every operation.

// File: rtl/lcd_frame_pkg.sv
package lcd_frame_pkg;
  localparam int NCOLS  = 40;
  localparam int NROWS  = 4;
  localparam int BYTE_W = 8;
  localparam int PW     = $clog2(NCOLS);

  typedef enum logic [1:0] {
    MUX_STATIC = 2'd0,
    MUX_HALF   = 2'd1,
    MUX_THIRD  = 2'd2,
    MUX_QUART  = 2'd3
  } mux_mode_e;
endpackage

// File: rtl/lcd_slot_map.sv
module lcd_slot_map #(
  parameter int NROWS  = 4,
  parameter int BYTE_W = 8
) (
  input  logic [1:0]                         mode,
  input  logic [BYTE_W-1:0]                  wr_byte,
  output logic [BYTE_W-1:0][NROWS-1:0]       col_mask,
  output logic [BYTE_W-1:0][NROWS-1:0]       col_dat,
  output logic [3:0]                         adv
);
  int k;
  int s;

  always_comb begin
    k = int'(mode) + 1;
    col_mask = '0;
    col_dat  = '0;
    for (int o = 0; o < BYTE_W; o++) begin
      for (int r = 0; r < NROWS; r++) begin
        s = o * k + r;
        if (r < k && s < BYTE_W) begin
          col_mask[o][r] = 1'b1;
          col_dat[o][r]  = wr_byte[BYTE_W-1-s];
        end
      end
    end
    adv = 4'((BYTE_W + k - 1) / k);
  end
endmodule

// File: rtl/lcd_col_ptr.sv
module lcd_col_ptr #(
  parameter int NCOLS = 40,
  parameter int PW    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_fire,
  input  logic          addr_load,
  input  logic [PW-1:0] addr_in,
  input  logic [3:0]    adv,
  output logic [PW-1:0] base,
  output logic [PW-1:0] ptr
);
  localparam int SW = PW + 1;
  logic [SW-1:0] sum;

  always_comb begin
    if (addr_load) base = (addr_in < PW'(NCOLS)) ? addr_in : '0;
    else           base = ptr;
    sum = {1'b0, base} + SW'(adv);
    if (sum >= SW'(NCOLS)) sum = sum - SW'(NCOLS);
  end

  always_ff @(posedge clk) begin
    if (rst)            ptr <= '0;
    else if (wr_fire)   ptr <= sum[PW-1:0];
    else if (addr_load) ptr <= base;
  end
endmodule

// File: rtl/lcd_cell_array.sv
module lcd_cell_array #(
  parameter int NCOLS  = 40,
  parameter int NROWS  = 4,
  parameter int BYTE_W = 8,
  parameter int PW     = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [PW-1:0]                base,
  input  logic [BYTE_W-1:0][NROWS-1:0] col_mask,
  input  logic [BYTE_W-1:0][NROWS-1:0] col_dat,
  input  logic [$clog2(NROWS)-1:0]     row_sel,
  output logic [NCOLS-1:0]             row_data,
  output logic [NROWS*NCOLS-1:0]       mem_flat
);
  localparam int SW = PW + 1;

  logic [BYTE_W-1:0][SW-1:0] tgt;
  logic [NCOLS-1:0][NROWS-1:0] cells;

  always_comb begin
    for (int o = 0; o < BYTE_W; o++) begin
      tgt[o] = {1'b0, base} + SW'(o);
      if (tgt[o] >= SW'(NCOLS)) tgt[o] = tgt[o] - SW'(NCOLS);
    end
  end

  for (genvar c = 0; c < NCOLS; c++) begin : g_col
    logic [NROWS-1:0] nxt;
    always_comb begin
      nxt = cells[c];
      for (int o = 0; o < BYTE_W; o++) begin
        if (we && tgt[o] == SW'(c))
          nxt = (nxt & ~col_mask[o]) | (col_dat[o] & col_mask[o]);
      end
    end
    always_ff @(posedge clk) begin
      if (rst) cells[c] <= '0;
      else     cells[c] <= nxt;
    end
    for (genvar r = 0; r < NROWS; r++) begin : g_row
      assign mem_flat[r*NCOLS + c] = cells[c][r];
    end
    assign row_data[c] = cells[c][row_sel];
  end
endmodule

// File: rtl/lcd_frame_store.sv
module lcd_frame_store
  import lcd_frame_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic [BYTE_W-1:0]     wr_byte,
  input  logic [1:0]            mode,
  input  logic                  addr_load,
  input  logic [PW-1:0]         addr_in,
  input  logic [1:0]            row_sel,
  output logic [NCOLS-1:0]      row_data
);
  logic                         wr_fire;
  logic [BYTE_W-1:0][NROWS-1:0] col_mask;
  logic [BYTE_W-1:0][NROWS-1:0] col_dat;
  logic [3:0]                   adv;
  logic [PW-1:0]                base;
  logic [PW-1:0]                ptr;
  logic [NROWS*NCOLS-1:0]       mem_flat;

  assign wr_ready = ~rst;
  assign wr_fire  = wr_valid & wr_ready;

  lcd_slot_map #(.NROWS(NROWS), .BYTE_W(BYTE_W)) u_map (
    .mode(mode), .wr_byte(wr_byte), .col_mask(col_mask), .col_dat(col_dat), .adv(adv)
  );

  lcd_col_ptr #(.NCOLS(NCOLS), .PW(PW)) u_ptr (
    .clk(clk), .rst(rst), .wr_fire(wr_fire), .addr_load(addr_load),
    .addr_in(addr_in), .adv(adv), .base(base), .ptr(ptr)
  );

  lcd_cell_array #(.NCOLS(NCOLS), .NROWS(NROWS), .BYTE_W(BYTE_W), .PW(PW)) u_arr (
    .clk(clk), .rst(rst), .we(wr_fire), .base(base), .col_mask(col_mask),
    .col_dat(col_dat), .row_sel(row_sel), .row_data(row_data), .mem_flat(mem_flat)
  );
endmodule

// File: rtl/lcd_frame_store_chk.sv
module lcd_frame_store_chk
  import lcd_frame_pkg::*;
(
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_valid,
  input logic                   addr_load,
  input logic [1:0]             mode,
  input logic [PW-1:0]          ptr,
  input logic [NROWS*NCOLS-1:0] mem_flat
);
  function automatic logic [PW-1:0] step(input logic [PW-1:0] p, input logic [1:0] m);
    int n;
    case (m)
      2'd0: n = int'(p) + 8;
      2'd1: n = int'(p) + 4;
      2'd2: n = int'(p) + 3;
      default: n = int'(p) + 2;
    endcase
    return PW'(n % NCOLS);
  endfunction

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    ptr < PW'(NCOLS)); // R7

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !addr_load) |=> ptr == step($past(ptr), $past(mode))); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> $stable(mem_flat)); // R2

  AST_STATIC_ROWS_KEPT: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && mode == 2'd0) |=> $stable(mem_flat[NROWS*NCOLS-1:NCOLS])); // R9

  AST_HALF_ROWS_KEPT: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && mode == 2'd1) |=> $stable(mem_flat[NROWS*NCOLS-1:2*NCOLS])); // R9
endmodule

bind lcd_frame_store lcd_frame_store_chk u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .addr_load(addr_load),
  .mode(mode), .ptr(ptr), .mem_flat(mem_flat)
);

// File: tb/lcd_frame_store_bench.sv
`timescale 1ns/1ps
module lcd_frame_store_bench;
  logic clk = 1'b0;
  logic rst;
  logic wr_valid, wr_ready, addr_load;
  logic [7:0] wr_byte;
  logic [1:0] mode, row_sel;
  logic [5:0] addr_in;
  logic [39:0] row_data;

  int checks = 0;
  int errors = 0;
  logic [39:0] mrow [4];
  int mptr;
  bit done = 0;

  always #2 clk = ~clk;

  lcd_frame_store u_lcd_frame_store (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_byte(wr_byte), .mode(mode), .addr_load(addr_load), .addr_in(addr_in),
    .row_sel(row_sel), .row_data(row_data)
  );

  function automatic int stride(input int m);
    return (8 + m) / (m + 1);
  endfunction

  task automatic model_write(input bit ld, input int a, input int m, input logic [7:0] b);
    int k, s, p;
    if (ld) mptr = (a < 40) ? a : 0;
    k = m + 1;
    for (int o = 0; o < 8; o++)
      for (int r = 0; r < k; r++) begin
        s = o * k + r;
        if (s < 8) begin
          p = (mptr + o) % 40;
          mrow[r][p] = b[7 - s];
        end
      end
    mptr = (mptr + stride(m)) % 40;
  endtask

  task automatic check(input bit cond, input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_rows(input string req);
    for (int r = 0; r < 4; r++) begin
      row_sel = 2'(r);
      #0.1;
      check(row_data === mrow[r], req, row_data, mrow[r]);
    end
  endtask

  task automatic op(input bit v, input bit ld, input int a, input int m, input logic [7:0] b);
    @(negedge clk);
    wr_valid = v; addr_load = ld; addr_in = 6'(a); mode = 2'(m); wr_byte = b;
    @(negedge clk);
    wr_valid = 0; addr_load = 0;
    if (v) model_write(ld, a, m, b);
    else if (ld) mptr = (a < 40) ? a : 0;
  endtask

  initial begin
    #700000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 40'd0, 40'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed1234;
    void'($urandom(seed));
    rst = 1; wr_valid = 0; addr_load = 0; addr_in = 0; mode = 0; wr_byte = 0; row_sel = 0;
    for (int r = 0; r < 4; r++) mrow[r] = '0;
    mptr = 0;
    // dirty the memory, then reset to show clearing (R8)
    repeat (2) @(negedge clk);
    rst = 0;
    op(1, 0, 0, 3, 8'hFF); op(1, 0, 0, 3, 8'hFF);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    for (int r = 0; r < 4; r++) mrow[r] = '0;
    mptr = 0;
    check_rows("R8 reset clears");
    check(wr_ready === 1'b1, "R11 ready", 40'(wr_ready), 40'd1);
    // R3 static at column 0
    op(1, 0, 0, 0, 8'hA5); check_rows("R3 static");
    // R4 1:2 continues at column 8
    op(1, 0, 0, 1, 8'h6C); check_rows("R4 half");
    // R6 1:4 continues at column 12
    op(1, 0, 0, 3, 8'h9E); check_rows("R6 quarter");
    // R5 preserved ninth slot
    op(1, 1, 20, 3, 8'hFF); op(1, 0, 0, 3, 8'hFF);
    op(1, 1, 20, 2, 8'h00); check_rows("R5 third");
    row_sel = 2; #0.1;
    check(row_data[22] === 1'b1, "R5 slot kept", 40'(row_data[22]), 40'd1);
    // R2 idle edges
    op(0, 0, 0, 0, 8'h00); op(0, 0, 0, 3, 8'hFF); check_rows("R2 idle");
    // R7 wrap within a byte
    op(1, 1, 38, 0, 8'hC3); check_rows("R7 wrap static");
    op(1, 1, 39, 3, 8'h5A); op(1, 0, 0, 1, 8'h3C); check_rows("R7 wrap quarter");
    // R10 out-of-range load and load-only
    op(1, 1, 45, 3, 8'h81); check_rows("R10 range");
    op(0, 1, 30, 0, 8'h00); op(1, 0, 0, 0, 8'hF0); check_rows("R10 load only");
    // R9 unused rows untouched (full ones first)
    op(1, 1, 0, 3, 8'hFF); op(1, 0, 0, 3, 8'hFF); op(1, 1, 0, 0, 8'h00);
    op(1, 1, 4, 1, 8'h00); check_rows("R9 unused rows");
    // R1 random mix
    for (int i = 0; i < 400; i++) begin
      int m, a;
      bit ld, v;
      m  = int'($urandom_range(0, 3));
      a  = int'($urandom_range(0, 63));
      ld = ($urandom_range(0, 5) == 0);
      v  = ($urandom_range(0, 7) != 0);
      op(v, ld, a, m, 8'($urandom));
      check_rows("R1 random");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule